// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical byte address into a 28-bit physical byte address. It walks a two-level translation table that lives in physical memory. A caller presents an address together with the frame number of the top-level table. The walker then makes two dependent 16-bit reads through a simple memory port and hands back the translated address.

The logical address is split, from the top down, into a 9-bit directory index, an 11-bit leaf index and a 12-bit byte offset. The directory read returns the frame that holds the leaf table. The leaf read returns the frame that holds the data. The offset is appended to that frame unchanged. Only one translation is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: The first read of a walk goes to byte address `{root_frame, 12'h000} + 2*laddr[31:23]`, using the root frame sampled at acceptance.
- R3: The second read goes to `{D, 12'h000} + 2*laddr[22:12]`, where D is the 16-bit word returned by the first read. It is issued only after that word has arrived.
- R4: The returned address is `{L, laddr[11:0]}`, where L is the 16-bit word returned by the second read.
- R5: Once raised, `mem_req` stays high with an unchanged `mem_addr` until a cycle in which `mem_gnt` is 1. Each grant starts exactly one read.
- R6: The walker waits any number of cycles for `mem_rvalid`. `rsp_valid` rises only after both reads of the walk have returned data.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_paddr` does not change.
- R8: `req_ready` is 1 only when no walk is in progress. During a walk it is 0, and no new request is taken.
- R9: Changes on `root_frame` and `req_laddr` after a request is accepted have no effect on that walk's reads or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_laddr | input | 32 | Logical byte address |
| root_frame | input | 16 | Frame number of the top-level table |
| rsp_valid | output | 1 | Translated address present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 28 | Physical byte address |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 28 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Read data (a frame number) |

## Verification
The hardest behaviour to reach from the ports is a walk in which every stage stalls. That means the read request waits several cycles for a grant, the data comes back after a variable delay, and the response is held against a consumer that is not ready. In that walk the root frame and the address inputs also change under the walker. The bench memory model grants requests at random with a fixed seed and returns data 1 to 4 cycles after each grant. The consumer's ready is drawn at random each cycle. The request inputs are scrambled right after acceptance. Directed walks at all-zero and all-one addresses and root frames cover the edges of the entry address arithmetic.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_DIR   = 2'd1,
    WS_LEAF  = 2'd2,
    WS_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_field_split.sv
module ptw_field_split #(
  parameter int LA_W    = 32,
  parameter int DIR_W   = 9,
  parameter int OFF_W   = 12,
  localparam int LEAF_W = LA_W - DIR_W - OFF_W
) (
  input  logic [LA_W-1:0]   laddr,
  output logic [DIR_W-1:0]  dir_idx,
  output logic [LEAF_W-1:0] leaf_idx,
  output logic [OFF_W-1:0]  offset
);
  assign dir_idx  = laddr[LA_W-1 -: DIR_W];
  assign leaf_idx = laddr[OFF_W +: LEAF_W];
  assign offset   = laddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int FRAME_W  = 16,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 9,
  parameter int ENT_LOG2 = 1,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic [FRAME_W-1:0] table_frame,
  input  logic [IDX_W-1:0]   idx,
  output logic [PA_W-1:0]    entry_addr
);
  function automatic logic [PA_W-1:0] entry_byte_addr(
    input logic [FRAME_W-1:0] frame,
    input logic [IDX_W-1:0]   index
  );
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;
    base = {frame, {OFF_W{1'b0}}};
    disp = PA_W'(index) << ENT_LOG2;
    return base + disp;
  endfunction

  assign entry_addr = entry_byte_addr(table_frame, idx);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LA_W     = 32,
  parameter int FRAME_W  = 16,
  parameter int OFF_W    = 12,
  parameter int DIR_W    = 9,
  parameter int ENT_LOG2 = 1,
  localparam int LEAF_W  = LA_W - DIR_W - OFF_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_laddr,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req,
  input  logic               mem_gnt,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [FRAME_W-1:0] mem_rdata
);
  walk_state_e        st_q;
  logic [LA_W-1:0]    la_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] frame_q;
  logic               issued_q;

  logic [DIR_W-1:0]   dir_idx;
  logic [LEAF_W-1:0]  leaf_idx;
  logic [OFF_W-1:0]   offset;
  logic [PA_W-1:0]    dir_entry_addr;
  logic [PA_W-1:0]    leaf_entry_addr;

  // named events for the assertions
  logic in_read;
  logic accept;
  logic grant;
  logic rd_done;
  logic consume;

  ptw_field_split #(.LA_W(LA_W), .DIR_W(DIR_W), .OFF_W(OFF_W)) u_split (
    .laddr   (la_q),
    .dir_idx (dir_idx),
    .leaf_idx(leaf_idx),
    .offset  (offset)
  );

  ptw_entry_addr #(.FRAME_W(FRAME_W), .OFF_W(OFF_W), .IDX_W(DIR_W),
                   .ENT_LOG2(ENT_LOG2)) u_dir_addr (
    .table_frame(root_q),
    .idx        (dir_idx),
    .entry_addr (dir_entry_addr)
  );

  ptw_entry_addr #(.FRAME_W(FRAME_W), .OFF_W(OFF_W), .IDX_W(LEAF_W),
                   .ENT_LOG2(ENT_LOG2)) u_leaf_addr (
    .table_frame(frame_q),
    .idx        (leaf_idx),
    .entry_addr (leaf_entry_addr)
  );

  assign in_read   = (st_q == WS_DIR) || (st_q == WS_LEAF);
  assign req_ready = (st_q == WS_IDLE);
  assign rsp_valid = (st_q == WS_RESP);
  assign mem_req   = in_read && !issued_q;
  assign mem_addr  = (st_q == WS_DIR) ? dir_entry_addr : leaf_entry_addr;
  assign rsp_paddr = {frame_q, offset};

  assign accept  = req_valid && req_ready;
  assign grant   = mem_req && mem_gnt;
  assign rd_done = in_read && issued_q && mem_rvalid;
  assign consume = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= WS_IDLE;
      la_q     <= '0;
      root_q   <= '0;
      frame_q  <= '0;
      issued_q <= 1'b0;
    end else begin
      unique case (st_q)
        WS_IDLE: begin
          if (accept) begin
            la_q     <= req_laddr;
            root_q   <= root_frame;
            issued_q <= 1'b0;
            st_q     <= WS_DIR;
          end
        end
        WS_DIR, WS_LEAF: begin
          if (grant) begin
            issued_q <= 1'b1;
          end else if (rd_done) begin
            frame_q  <= mem_rdata;
            issued_q <= 1'b0;
            st_q     <= (st_q == WS_DIR) ? WS_LEAF : WS_RESP;
          end
        end
        WS_RESP: begin
          if (consume) st_q <= WS_IDLE;
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  // checks
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst) begin
      AST_RESET_IDLE: assert (req_ready && !mem_req && !rsp_valid); // R1
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)); // R7

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req && !rsp_valid); // R8

  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(mem_rvalid)); // R6

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ENT_LOG2-1:0] == '0)); // R2
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic [15:0] root_frame = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [27:0] rsp_paddr;
  logic        mem_req;
  logic        mem_gnt = 1'b0;
  logic [27:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  logic [27:0] exp_dir, exp_leaf, exp_pa;
  int rd_idx = 0;
  int rv_cnt = 0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .root_frame(root_frame),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_word(input logic [27:0] a);
    return a[16:1] ^ {a[27:20], a[8:1]} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random grant delay, 1..4 cycle read latency
  initial begin
    bit busy = 0;
    int lat = 0;
    bit waiting = 0;
    logic [27:0] held = '0;
    logic [27:0] wait_addr = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_gnt = 1'b0;
      if (rst) begin
        busy = 0; waiting = 0;
        continue;
      end
      if (busy) begin
        lat--;
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = mem_word(held);
          busy = 0;
          rv_cnt++;
        end
      end else begin
        if (waiting) begin
          chk(mem_req && mem_addr == wait_addr, "R5", {3'b0, mem_req, mem_addr},
              {4'b0001, wait_addr});
          waiting = 0;
        end
        if (mem_req) begin
          if ($urandom % 2 == 0) begin
            mem_gnt = 1'b1;
            busy = 1;
            lat = 1 + int'($urandom % 4);
            held = mem_addr;
            if (rd_idx == 0)
              chk(mem_addr == exp_dir, "R2", {4'b0, mem_addr}, {4'b0, exp_dir});
            else
              chk(mem_addr == exp_leaf && rv_cnt == 1, "R3",
                  {4'b0, mem_addr}, {4'b0, exp_leaf});
            rd_idx++;
          end else begin
            waiting = 1;
            wait_addr = mem_addr;
          end
        end
      end
    end
  end

  task automatic translate(input logic [31:0] la, input logic [15:0] root);
    logic [15:0] d, l;
    bit got;
    bit first;
    exp_dir  = {root, 12'h000} + {18'b0, la[31:23], 1'b0};
    d        = mem_word(exp_dir);
    exp_leaf = {d, 12'h000} + {16'b0, la[22:12], 1'b0};
    l        = mem_word(exp_leaf);
    exp_pa   = {l, la[11:0]};
    rd_idx = 0;
    rv_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    root_frame = root;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_laddr = $urandom;          // R9: scramble inputs after acceptance
    root_frame = 16'($urandom);
    got = 0;
    first = 1;
    while (!got) begin
      if (rsp_valid) begin
        if (first) begin
          chk(rv_cnt == 2, "R6", rv_cnt, 2);
          chk(rsp_paddr == exp_pa, "R4 R9", {4'b0, rsp_paddr}, {4'b0, exp_pa});
          first = 0;
        end else begin
          chk(rsp_paddr == exp_pa, "R7", {4'b0, rsp_paddr}, {4'b0, exp_pa});
        end
        rsp_ready = ($urandom % 3 == 0);
        if (rsp_ready) got = 1;
      end else begin
        chk(!req_ready, "R8", {31'b0, req_ready}, 0);
        rsp_ready = ($urandom % 2 == 0);
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R8", {30'b0, req_ready, rsp_valid}, 2);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R1",
        {29'b0, req_ready, mem_req, rsp_valid}, 4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R1",
        {29'b0, req_ready, mem_req, rsp_valid}, 4);
    translate(32'h0000_0000, 16'h0000);
    translate(32'hFFFF_FFFF, 16'hFFFF);
    translate(32'hFF80_0000, 16'h0001);
    translate(32'h007F_F123, 16'h8000);
    for (int i = 0; i < 60; i++) translate($urandom, 16'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule